// File: doc/BRIEF.md
# Clock Output and Multiplier Control Register

This block is an 8-bit control register on the CPU register bus. It decides what the system clock output pin does in each power mode, and it decides when a new PLL multiplication factor reaches the PLL. Software writes the register through a pre-decoded write strobe. The contents can be read back at any time on the read data port.

The pin has three possible states: it carries the clock, it is held high, or it is released to high impedance. Which state applies depends on the power-mode code, the hardware-standby input and a disable bit in the register. The pin selection is registered, so a change of mode or of the disable bit reaches the pin at the next clock edge and never in the middle of a cycle.

The multiplier path has two switching modes. In deferred mode, the pending factor is copied to the PLL only when a one-cycle strobe marks entry into software standby, watch or sub-active mode. In immediate mode, the active factor follows the pending value, one cycle behind it.

Top module: `clkout_mult_ctrl`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` bit 7 (output disable), bit 3 (switching mode) and bits 2..0 (speed select). The value is readable on `rd_data` from the next cycle. After reset, `rd_data` is 0x00.
- R2: `rst` or `hw_standby` held high at a clock edge clears the register and the active multiplier to 0. This clear takes priority over a write in the same cycle.
- R3: Bits 6, 5 and 4 always read as 0, and writing 1 to them has no effect.
- R4: When `pmode` is 0 to 4 (high-speed 0, medium-speed 1, sub-active 2, sleep 3, sub-sleep 4) and `hw_standby` is low, the pin selection is updated one cycle after the inputs it depends on. With the disable bit at 0, `pin_out` follows `src_clk` and `pin_oe` is 1. With the disable bit at 1, `pin_out` is held at 1.
- R5: When `pmode` is 5 (software standby), 6 (watch) or 7 (unused code), the next cycle has `pin_oe` = 1 and `pin_out` = 1, whatever the value of the disable bit.
- R6: A cycle with `hw_standby` high makes `pin_oe` 0 (high impedance) in the next cycle, whatever the values of the mode and the disable bit.
- R7: With register bit 3 at 0, `mult_active` changes only at an edge where `lp_entry` is high. At that edge it loads `pend_mult`.
- R8: With register bit 3 at 1, `mult_active` equals the `pend_mult` value from the previous cycle.
- R9: Being in software standby mode (`pmode` = 5) leaves the register contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_standby | input | 1 | Hardware standby: clears the register and floats the pin |
| pmode | input | 3 | Encoded power mode |
| lp_entry | input | 1 | One-cycle strobe on entry to software standby, watch or sub-active mode |
| wr_en | input | 1 | Address-decoded register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| src_clk | input | 1 | Clock to be driven on the output pin |
| pend_mult | input | MULT_W | Pending multiplication factor |
| pin_out | output | 1 | Pin drive level |
| pin_oe | output | 1 | Pin output enable (0 means high impedance) |
| mult_active | output | MULT_W | Multiplication factor applied to the PLL |

## Verification
The directed cases step through every power-mode code with the disable bit at both 0 and 1. They also toggle `src_clk` in each case, which separates a pin that passes the clock from a pin held high. Further directed cases cover hardware standby asserted alone and together with a write, which shows whether the clear takes priority. The multiplier is tested by changing `pend_mult` with and without the strobe in each switching mode, which separates deferred commit from immediate commit. A seeded random phase then mixes writes, mode changes, strobes and standby pulses, and compares every output cycle by cycle against a bench model built from the requirements.

// File: rtl/clkout_ctrl_pkg.sv
package clkout_ctrl_pkg;

    localparam int REG_W = 8;

    // Only the disable bit, the switching mode bit and the speed field are writable.
    localparam logic [REG_W-1:0] WRITE_MASK = 8'h8F;

    typedef enum logic [2:0] {
        PM_HIGH     = 3'd0,
        PM_MEDIUM   = 3'd1,
        PM_SUBACT   = 3'd2,
        PM_SLEEP    = 3'd3,
        PM_SUBSLEEP = 3'd4,
        PM_SWSTBY   = 3'd5,
        PM_WATCH    = 3'd6,
        PM_UNUSED   = 3'd7
    } pmode_e;

    typedef struct packed {
        logic       out_off;
        logic [2:0] rsvd;
        logic       switch_now;
        logic [2:0] speed;
    } ctrl_reg_t;

    typedef enum logic [1:0] {
        PIN_HIZ   = 2'd0,
        PIN_HIGH  = 2'd1,
        PIN_CLOCK = 2'd2
    } pin_sel_e;

    function automatic logic mode_runs_clock(input logic [2:0] mode);
        return (mode <= PM_SUBSLEEP);
    endfunction

    function automatic pin_sel_e pick_pin(input logic hw, input logic [2:0] mode,
                                          input logic off);
        if (hw)
            return PIN_HIZ;
        else if (mode_runs_clock(mode) && !off)
            return PIN_CLOCK;
        else
            return PIN_HIGH;
    endfunction

endpackage

// File: rtl/ckoc_reg.sv
module ckoc_reg
    import clkout_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_standby,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctrl_reg_t        ctrl_q
);

    ctrl_reg_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en)
            ctrl_d = ctrl_reg_t'(wr_data & WRITE_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst || hw_standby)
            ctrl_q <= '0;
        else
            ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/ckoc_pin_gate.sv
module ckoc_pin_gate
    import clkout_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hw_standby,
    input  logic [2:0] pmode,
    input  logic       out_off,
    input  logic       src_clk,
    output logic       pin_out,
    output logic       pin_oe
);

    pin_sel_e sel_q;

    // Standby floats the pin even while reset is held.
    always_ff @(posedge clk) begin
        if (hw_standby)
            sel_q <= PIN_HIZ;
        else if (rst)
            sel_q <= PIN_HIGH;
        else
            sel_q <= pick_pin(1'b0, pmode, out_off);
    end

    assign pin_oe  = (sel_q != PIN_HIZ);
    assign pin_out = (sel_q == PIN_CLOCK) ? src_clk : 1'b1;

endmodule

// File: rtl/ckoc_mult_commit.sv
module ckoc_mult_commit #(
    parameter int MULT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_standby,
    input  logic              switch_now,
    input  logic              lp_entry,
    input  logic [MULT_W-1:0] pend_mult,
    output logic [MULT_W-1:0] mult_q
);

    logic load;

    assign load = switch_now || lp_entry;

    always_ff @(posedge clk) begin
        if (rst || hw_standby)
            mult_q <= '0;
        else if (load)
            mult_q <= pend_mult;
    end

endmodule

// File: rtl/clkout_mult_ctrl.sv
module clkout_mult_ctrl
    import clkout_ctrl_pkg::*;
#(
    parameter int MULT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_standby,
    input  logic [2:0]        pmode,
    input  logic              lp_entry,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              src_clk,
    input  logic [MULT_W-1:0] pend_mult,
    output logic              pin_out,
    output logic              pin_oe,
    output logic [MULT_W-1:0] mult_active
);

    ctrl_reg_t ctrl_q;

    ckoc_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .hw_standby (hw_standby),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ctrl_q     (ctrl_q)
    );

    ckoc_pin_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .hw_standby (hw_standby),
        .pmode      (pmode),
        .out_off    (ctrl_q.out_off),
        .src_clk    (src_clk),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    ckoc_mult_commit #(.MULT_W(MULT_W)) u_mult (
        .clk        (clk),
        .rst        (rst),
        .hw_standby (hw_standby),
        .switch_now (ctrl_q.switch_now),
        .lp_entry   (lp_entry),
        .pend_mult  (pend_mult),
        .mult_q     (mult_active)
    );

    assign rd_data = ctrl_q;

endmodule

// File: rtl/clkout_mult_ctrl_chk.sv
module clkout_mult_ctrl_chk
    import clkout_ctrl_pkg::*;
#(
    parameter int MULT_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              hw_standby,
    input logic [2:0]        pmode,
    input logic              lp_entry,
    input logic [7:0]        rd_data,
    input logic              src_clk,
    input logic [MULT_W-1:0] pend_mult,
    input logic              pin_out,
    input logic              pin_oe,
    input logic [MULT_W-1:0] mult_active
);

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        rd_data[6:4] == 3'b000);

    a_r2_standby_clears: assert property (@(posedge clk) disable iff (rst)
        hw_standby |=> (rd_data == 8'h00) && (mult_active == '0));

    a_r6_standby_floats: assert property (@(posedge clk) disable iff (rst)
        hw_standby |=> !pin_oe);

    a_r5_quiet_modes_high: assert property (@(posedge clk) disable iff (rst)
        (!hw_standby && !mode_runs_clock(pmode)) |=> (pin_oe && pin_out));

    a_r4_clock_passes: assert property (@(posedge clk) disable iff (rst)
        (!hw_standby && mode_runs_clock(pmode) && !rd_data[7]) |=>
            (pin_oe && (pin_out == src_clk)));

    a_r4_disabled_high: assert property (@(posedge clk) disable iff (rst)
        (!hw_standby && rd_data[7]) |=> (pin_oe && pin_out));

    a_r7_deferred_hold: assert property (@(posedge clk) disable iff (rst)
        (!hw_standby && !rd_data[3] && !lp_entry) |=> $stable(mult_active));

    a_r8_immediate_follow: assert property (@(posedge clk) disable iff (rst)
        (!hw_standby && rd_data[3]) |=> (mult_active == $past(pend_mult)));

endmodule

bind clkout_mult_ctrl clkout_mult_ctrl_chk #(.MULT_W(MULT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hw_standby  (hw_standby),
    .pmode       (pmode),
    .lp_entry    (lp_entry),
    .rd_data     (rd_data),
    .src_clk     (src_clk),
    .pend_mult   (pend_mult),
    .pin_out     (pin_out),
    .pin_oe      (pin_oe),
    .mult_active (mult_active)
);

// File: tb/tb_clkout_mult_ctrl.sv
module tb_clkout_mult_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int MW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          hw = 1'b0;
    logic [2:0]    pmode = 3'd0;
    logic          lp = 1'b0;
    logic          we = 1'b0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rd_data;
    logic          sclk = 1'b0;
    logic [MW-1:0] pend = '0;
    logic          pin_out, pin_oe;
    logic [MW-1:0] mult_active;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0]    m_reg = 8'h00;
    logic          m_oe = 1'b1;
    logic          m_pass = 1'b0;
    logic [MW-1:0] m_mult = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkout_mult_ctrl #(.MULT_W(MW)) dut (
        .clk(clk), .rst(rst), .hw_standby(hw), .pmode(pmode), .lp_entry(lp),
        .wr_en(we), .wr_data(wdata), .rd_data(rd_data), .src_clk(sclk),
        .pend_mult(pend), .pin_out(pin_out), .pin_oe(pin_oe), .mult_active(mult_active)
    );

    function automatic logic runs(input logic [2:0] m);
        return m <= 3'd4;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one edge, update the model from the inputs seen at that edge, then compare.
    task automatic step();
        logic [7:0] old;
        @(posedge clk);
        old = m_reg;
        if (rst || hw) begin
            m_reg  = 8'h00;
            m_mult = '0;
        end else begin
            if (we) m_reg = wdata & 8'h8F;
            if (old[3] || lp) m_mult = pend;
        end
        m_oe   = !hw;
        m_pass = !hw && !rst && runs(pmode) && !old[7];
        #1;
        check(rd_data == m_reg, "R1 rd_data", rd_data, m_reg);
        check(pin_oe == m_oe, "R6 pin_oe", pin_oe, m_oe);
        if (m_oe)
            check(pin_out == (m_pass ? sclk : 1'b1), "R4 pin_out", pin_out,
                  m_pass ? sclk : 1'b1);
        check(mult_active == m_mult, "R7 mult_active", mult_active, m_mult);
    endtask

    task automatic idle();
        we = 1'b0; lp = 1'b0; hw = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        step(); step();
        check(rd_data == 8'h00, "R1 reset value", rd_data, 0);
        rst = 1'b0;
        step();

        // R3: reserved bits stay 0 after writing all ones
        we = 1'b1; wdata = 8'hFF; step(); idle();
        check(rd_data == 8'h8F, "R3 reserved bits", rd_data, 8'h8F);
        we = 1'b1; wdata = 8'h70; step(); idle();
        check(rd_data == 8'h00, "R3 reserved only write", rd_data, 0);

        // R4 and R5: every mode with the disable bit at both values
        for (int off = 0; off < 2; off++) begin
            we = 1'b1; wdata = off ? 8'h80 : 8'h00; step(); idle();
            for (int m = 0; m < 8; m++) begin
                pmode = m[2:0];
                step();
                for (int t = 0; t < 2; t++) begin
                    sclk = ~sclk; #1;
                    if (m <= 4 && off == 0)
                        check(pin_out == sclk && pin_oe, "R4 clock passes", pin_out, sclk);
                    else
                        check(pin_out == 1'b1 && pin_oe, "R5 pin held high", pin_out, 1);
                end
                step();
            end
        end

        // R9: software standby keeps the register
        pmode = 3'd0; we = 1'b1; wdata = 8'h85; step(); idle();
        pmode = 3'd5; step(); step(); step();
        check(rd_data == 8'h85, "R9 standby keeps value", rd_data, 8'h85);

        // R6 and R2: hardware standby floats pin and clears, even with a write
        hw = 1'b1; we = 1'b1; wdata = 8'h8F; step(); idle();
        check(pin_oe == 1'b0, "R6 high impedance", pin_oe, 0);
        check(rd_data == 8'h00, "R2 standby beats write", rd_data, 0);
        pmode = 3'd0; step();

        // R7: deferred commit waits for the strobe
        we = 1'b1; wdata = 8'h00; step(); idle();
        pend = 3'd5; step(); step();
        check(mult_active == '0, "R7 no strobe no change", mult_active, 0);
        lp = 1'b1; step(); lp = 1'b0;
        check(mult_active == 3'd5, "R7 strobe loads", mult_active, 5);

        // R8: immediate mode follows pend_mult
        we = 1'b1; wdata = 8'h08; step(); idle();
        pend = 3'd2; step();
        check(mult_active == 3'd2, "R8 immediate", mult_active, 2);
        pend = 3'd7; step();
        check(mult_active == 3'd7, "R8 immediate again", mult_active, 7);

        // R2: reset clears multiplier and register
        rst = 1'b1; step(); rst = 1'b0;
        check(rd_data == 8'h00 && mult_active == '0, "R2 reset clears", rd_data, 0);

        // Random phase
        for (int i = 0; i < 2000; i++) begin
            we    = ($urandom % 4) == 0;
            wdata = 8'($urandom);
            pmode = 3'($urandom);
            lp    = ($urandom % 8) == 0;
            hw    = ($urandom % 40) == 0;
            rst   = ($urandom % 200) == 0;
            pend  = MW'($urandom);
            sclk  = 1'($urandom);
            step();
        end
        rst = 1'b0; idle(); step();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule